// File: doc/BRIEF.md
# Multi-rail startup sequencer

This block sequences the start of a four-rail regulator system. Comparator results arrive as synchronous flags: three supply-present flags (bias, 5 V, 3.3 V), a termination-rail flag that says the rail is above 90 % of its target, under-voltage-clear flags for the termination, graphics and chipset rails, a core-output in-window flag and a strobe for each PWM pulse. The block sends out enables for the core, termination and graphics regulators, an always-on enable and a full-level flag for the chipset rail, the values of two soft-start ramps, a termination power-good and a global power-good.

Each ramp is an 8-bit saturating counter at 20 mV per LSB. It moves by one step on each `tick` pulse. The first ramp starts once all supplies are present. It jumps at once to its initial level and then climbs. The second ramp waits until the termination rail is near its target. The termination power-good is tied to the first PWM pulse after the second ramp has reached the oscillator valley level. A separate retry block drives `inhibit` and `restart`. `shut_req` forces the first ramp low.

Top module: `rail_seq_top`

## Requirements
- R1: The first ramp stays at 0 until `sup_bias`, `sup_5v` and `sup_3v3` are all high. When any supply is low at an edge, the ramp reads 0 two edges later. Partial supply sets have no effect on it.
- R2: Once released, the first ramp jumps to 50 (1.0 V) at the next edge. It then adds 1 on each `tick` and saturates at 225 (4.5 V).
- R3: The second ramp stays at 0 until `vtt_90` has been seen high. It then starts from 0, adds 1 per `tick` and saturates at 225. It is held at 0 while the first ramp is below 40 (0.8 V).
- R4: `vtt_pg` sets on a `pwm_pulse` seen while the second ramp is at least 63 (1.25 V). A pulse below that level does not set it. `vtt_pg` holds while `vtt_uv_ok` stays high, clears at the edge after `vtt_uv_ok` goes low, and then waits for a new pulse.
- R5: `pgood` is high only when the rails are live, both ramps are above 200, and `core_win`, `vtt_uv_ok`, `agp_uv_ok` and `mch_uv_ok` are all high.
- R6: `ramp_a_up` and `ramp_b_up` each show, one edge late, that their ramp is above 200 (4.0 V).
- R7: While `shut_req` is high, the first ramp is 0, `en_core`, `en_vtt` and `en_agp` drop, and `mch_full` drops to the intermediate level. `en_mch` stays high.
- R8: `en_mch` is high from the first edge after reset, whatever the supply flags show.
- R9: `inhibit` clears `pgood`, `vtt_pg`, the three rail enables and the second ramp at the next edge.
- R10: A `restart` pulse sets both ramps to 0 at the next edge, and a fresh soft-start follows.
- R11: `en_vtt` is high while the rails are live (supplies present, first ramp at least 40, no inhibit). `en_agp` additionally needs the second ramp to be released. `en_core` additionally needs the second ramp to be at least 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Ramp step enable |
| sup_bias | input | 1 | Bias supply above its threshold |
| sup_5v | input | 1 | 5 V supply above its threshold |
| sup_3v3 | input | 1 | 3.3 V supply above its threshold |
| shut_req | input | 1 | Force the first ramp low |
| inhibit | input | 1 | Retry block: hold rails 1 to 3 off |
| restart | input | 1 | Retry block: begin a new soft-start |
| vtt_90 | input | 1 | Termination rail above 90 % of target |
| vtt_uv_ok | input | 1 | Termination rail above 1.08 V |
| agp_uv_ok | input | 1 | Graphics rail above its UV level |
| mch_uv_ok | input | 1 | Chipset rail above its UV level |
| core_win | input | 1 | Core output within ±10 % of its reference |
| pwm_pulse | input | 1 | One strobe per PWM pulse |
| en_core | output | 1 | Core PWM enable |
| en_vtt | output | 1 | Termination regulator enable |
| en_agp | output | 1 | Graphics regulator enable |
| en_mch | output | 1 | Chipset regulator enable |
| mch_full | output | 1 | Chipset rail at full level (0 = intermediate) |
| ramp_a | output | 8 | First soft-start ramp, 20 mV/LSB |
| ramp_b | output | 8 | Second soft-start ramp, 20 mV/LSB |
| ramp_a_up | output | 1 | First ramp fully charged |
| ramp_b_up | output | 1 | Second ramp fully charged |
| vtt_pg | output | 1 | Termination power-good |
| pgood | output | 1 | Global power-good |

## Verification
A wrong release latch shows up as a second ramp that moves before `vtt_90`, or never moves. It also shows on `en_agp` one edge later than the fault. A mistake in a threshold decode moves the edge on which `en_core`, the up flags or `vtt_pg` change by at least one tick. So a per-edge comparison of every output against an independent model catches it the cycle the level is crossed. A bad clear path (shutdown, inhibit, restart or supply loss) leaves a ramp or an enable high on the edge after the event, where both the comparison and the bound properties catch it.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  // millivolt level to counter code, rounded up so a decode never fires early
  function automatic int mv_to_lsb(input int mv, input int step);
    return (mv + step - 1) / step;
  endfunction

  typedef struct packed {
    logic core;
    logic vtt;
    logic agp;
  } rail_en_t;

endpackage

// File: rtl/seq_supply_mon.sv
module seq_supply_mon #(
  parameter int N_SUP = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SUP-1:0] sup_vec,
  output logic             por_ok,
  output logic             mch_on
);

  always_ff @(posedge clk) begin
    if (rst) begin
      por_ok <= 1'b0;
      mch_on <= 1'b0;
    end else begin
      por_ok <= &sup_vec;
      mch_on <= 1'b1;
    end
  end

endmodule

// File: rtl/seq_ramp.sv
module seq_ramp #(
  parameter int W        = 8,
  parameter int INIT_LVL = 0,
  parameter int TOP_LVL  = 225,
  parameter int UP_LVL   = 200
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  input  logic         tick,
  output logic [W-1:0] lvl,
  output logic         up
);

  localparam logic [W-1:0] L_INIT = W'(INIT_LVL);
  localparam logic [W-1:0] L_TOP  = W'(TOP_LVL);
  localparam logic [W-1:0] L_UP   = W'(UP_LVL);

  logic [W-1:0] lvl_nx;
  logic         step_ok;

  assign step_ok = adv & tick & (lvl < L_TOP);

  generate
    if (INIT_LVL > 0) begin : g_jump
      always_comb begin
        if (lvl < L_INIT)   lvl_nx = L_INIT;
        else if (step_ok)   lvl_nx = lvl + 1'b1;
        else                lvl_nx = lvl;
      end
    end else begin : g_plain
      always_comb begin
        if (step_ok) lvl_nx = lvl + 1'b1;
        else         lvl_nx = lvl;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) lvl <= '0;
    else            lvl <= lvl_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) up <= 1'b0;
    else     up <= (lvl > L_UP);
  end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl #(
  parameter int W          = 8,
  parameter int SHUT_LVL   = 40,
  parameter int VALLEY_LVL = 63,
  parameter int UP_LVL     = 200
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         por_ok,
  input  logic         clr_a,
  input  logic [W-1:0] ramp_a,
  input  logic [W-1:0] ramp_b,
  input  logic         inhibit,
  input  logic         vtt_90,
  input  logic         vtt_uv_ok,
  input  logic         agp_uv_ok,
  input  logic         mch_uv_ok,
  input  logic         core_win,
  input  logic         pwm_pulse,
  output logic         clr_b,
  output logic         b_rel,
  output rail_seq_pkg::rail_en_t rails,
  output logic         mch_full,
  output logic         vtt_pg,
  output logic         pgood
);

  localparam logic [W-1:0] L_SHUT   = W'(SHUT_LVL);
  localparam logic [W-1:0] L_VALLEY = W'(VALLEY_LVL);
  localparam logic [W-1:0] L_UP     = W'(UP_LVL);

  logic a_above_shut, b_at_valley, live, both_up, rails_ok;

  assign a_above_shut = (ramp_a >= L_SHUT);
  assign b_at_valley  = (ramp_b >= L_VALLEY);
  assign live         = por_ok & a_above_shut & ~inhibit;
  assign clr_b        = clr_a | inhibit | ~a_above_shut;
  assign both_up      = (ramp_a > L_UP) & (ramp_b > L_UP);
  assign rails_ok     = core_win & vtt_uv_ok & agp_uv_ok & mch_uv_ok;

  always_ff @(posedge clk) begin
    if (rst || clr_b) b_rel <= 1'b0;
    else if (vtt_90)  b_rel <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rails    <= '0;
      mch_full <= 1'b0;
      vtt_pg   <= 1'b0;
      pgood    <= 1'b0;
    end else begin
      rails.vtt <= live;
      rails.agp <= live & b_rel;
      rails.core <= live & b_at_valley;
      mch_full  <= por_ok & a_above_shut;
      if (!live || !vtt_uv_ok)           vtt_pg <= 1'b0;
      else if (pwm_pulse && b_at_valley) vtt_pg <= 1'b1;
      pgood <= live & both_up & rails_ok;
    end
  end

endmodule

// File: rtl/rail_seq_top.sv
module rail_seq_top #(
  parameter int RAMP_W    = 8,
  parameter int STEP_MV   = 20,
  parameter int INIT_MV   = 1000,
  parameter int TOP_MV    = 4500,
  parameter int UP_MV     = 4000,
  parameter int VALLEY_MV = 1250,
  parameter int SHUT_MV   = 800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              sup_bias,
  input  logic              sup_5v,
  input  logic              sup_3v3,
  input  logic              shut_req,
  input  logic              inhibit,
  input  logic              restart,
  input  logic              vtt_90,
  input  logic              vtt_uv_ok,
  input  logic              agp_uv_ok,
  input  logic              mch_uv_ok,
  input  logic              core_win,
  input  logic              pwm_pulse,
  output logic              en_core,
  output logic              en_vtt,
  output logic              en_agp,
  output logic              en_mch,
  output logic              mch_full,
  output logic [RAMP_W-1:0] ramp_a,
  output logic [RAMP_W-1:0] ramp_b,
  output logic              ramp_a_up,
  output logic              ramp_b_up,
  output logic              vtt_pg,
  output logic              pgood
);

  localparam int INIT_LVL   = rail_seq_pkg::mv_to_lsb(INIT_MV, STEP_MV);
  localparam int TOP_LVL    = rail_seq_pkg::mv_to_lsb(TOP_MV, STEP_MV);
  localparam int UP_LVL     = rail_seq_pkg::mv_to_lsb(UP_MV, STEP_MV);
  localparam int VALLEY_LVL = rail_seq_pkg::mv_to_lsb(VALLEY_MV, STEP_MV);
  localparam int SHUT_LVL   = rail_seq_pkg::mv_to_lsb(SHUT_MV, STEP_MV);

  logic por_ok, clr_a, clr_b, b_rel;
  rail_seq_pkg::rail_en_t rails;

  seq_supply_mon #(.N_SUP(3)) sup_i (
    .clk(clk), .rst(rst),
    .sup_vec({sup_bias, sup_5v, sup_3v3}),
    .por_ok(por_ok), .mch_on(en_mch)
  );

  assign clr_a = ~por_ok | shut_req | restart;

  seq_ramp #(.W(RAMP_W), .INIT_LVL(INIT_LVL), .TOP_LVL(TOP_LVL), .UP_LVL(UP_LVL)) ramp_a_i (
    .clk(clk), .rst(rst), .clr(clr_a), .adv(1'b1), .tick(tick),
    .lvl(ramp_a), .up(ramp_a_up)
  );

  seq_ramp #(.W(RAMP_W), .INIT_LVL(0), .TOP_LVL(TOP_LVL), .UP_LVL(UP_LVL)) ramp_b_i (
    .clk(clk), .rst(rst), .clr(clr_b), .adv(b_rel), .tick(tick),
    .lvl(ramp_b), .up(ramp_b_up)
  );

  seq_ctrl #(.W(RAMP_W), .SHUT_LVL(SHUT_LVL), .VALLEY_LVL(VALLEY_LVL), .UP_LVL(UP_LVL)) ctrl_i (
    .clk(clk), .rst(rst), .por_ok(por_ok), .clr_a(clr_a),
    .ramp_a(ramp_a), .ramp_b(ramp_b), .inhibit(inhibit), .vtt_90(vtt_90),
    .vtt_uv_ok(vtt_uv_ok), .agp_uv_ok(agp_uv_ok), .mch_uv_ok(mch_uv_ok),
    .core_win(core_win), .pwm_pulse(pwm_pulse),
    .clr_b(clr_b), .b_rel(b_rel), .rails(rails), .mch_full(mch_full),
    .vtt_pg(vtt_pg), .pgood(pgood)
  );

  assign en_core = rails.core;
  assign en_vtt  = rails.vtt;
  assign en_agp  = rails.agp;

endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk #(
  parameter int RAMP_W   = 8,
  parameter int INIT_LVL = 50,
  parameter int TOP_LVL  = 225
) (
  input logic              clk,
  input logic              rst,
  input logic              sup_bias,
  input logic              sup_5v,
  input logic              sup_3v3,
  input logic              shut_req,
  input logic              inhibit,
  input logic              restart,
  input logic              en_core,
  input logic              en_vtt,
  input logic              en_agp,
  input logic              en_mch,
  input logic [RAMP_W-1:0] ramp_a,
  input logic [RAMP_W-1:0] ramp_b,
  input logic              ramp_a_up,
  input logic              ramp_b_up,
  input logic              vtt_pg,
  input logic              pgood
);

  localparam logic [RAMP_W-1:0] L_INIT = RAMP_W'(INIT_LVL);
  localparam logic [RAMP_W-1:0] L_TOP  = RAMP_W'(TOP_LVL);

  // R1
  supply_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !(sup_bias && sup_5v && sup_3v3) |-> ##2 (ramp_a == '0));

  // R2
  ramp_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    (ramp_a <= L_TOP) && (ramp_b <= L_TOP));

  // R2
  ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ramp_a > L_INIT) |->
      (($past(ramp_a) == ramp_a) || ({1'b0, $past(ramp_a)} + 1'b1 == {1'b0, ramp_a})));

  // R4
  vtt_pg_live_chk: assert property (@(posedge clk) disable iff (rst)
    vtt_pg |-> en_vtt);

  // R5
  pgood_up_chk: assert property (@(posedge clk) disable iff (rst)
    pgood |-> (ramp_a_up && ramp_b_up && en_vtt));

  // R7
  shutdown_clear_chk: assert property (@(posedge clk) disable iff (rst)
    shut_req |=> ((ramp_a == '0) && en_mch));

  // R8
  mch_always_on_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> en_mch);

  // R9
  inhibit_clear_chk: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> (!pgood && !vtt_pg && !en_vtt && !en_core && !en_agp && (ramp_b == '0)));

  // R10
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> ((ramp_a == '0) && (ramp_b == '0)));

endmodule

bind rail_seq_top rail_seq_chk #(.RAMP_W(RAMP_W), .INIT_LVL(INIT_LVL), .TOP_LVL(TOP_LVL)) chk_i (
  .clk(clk), .rst(rst), .sup_bias(sup_bias), .sup_5v(sup_5v), .sup_3v3(sup_3v3),
  .shut_req(shut_req), .inhibit(inhibit), .restart(restart),
  .en_core(en_core), .en_vtt(en_vtt), .en_agp(en_agp), .en_mch(en_mch),
  .ramp_a(ramp_a), .ramp_b(ramp_b), .ramp_a_up(ramp_a_up), .ramp_b_up(ramp_b_up),
  .vtt_pg(vtt_pg), .pgood(pgood)
);

// File: tb/rail_seq_top_tb_top.sv
module rail_seq_top_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic sup_bias = 0, sup_5v = 0, sup_3v3 = 0;
  logic shut_req = 0, inhibit = 0, restart = 0;
  logic vtt_90 = 0, vtt_uv_ok = 0, agp_uv_ok = 0, mch_uv_ok = 0, core_win = 0, pwm_pulse = 0;
  logic en_core, en_vtt, en_agp, en_mch, mch_full, ramp_a_up, ramp_b_up, vtt_pg, pgood;
  logic [7:0] ramp_a, ramp_b;

  int total = 0;
  int bad = 0;
  int tick_div = 1;
  int tick_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rail_seq_top dut_i (
    .clk(clk), .rst(rst), .tick(tick), .sup_bias(sup_bias), .sup_5v(sup_5v), .sup_3v3(sup_3v3),
    .shut_req(shut_req), .inhibit(inhibit), .restart(restart), .vtt_90(vtt_90),
    .vtt_uv_ok(vtt_uv_ok), .agp_uv_ok(agp_uv_ok), .mch_uv_ok(mch_uv_ok), .core_win(core_win),
    .pwm_pulse(pwm_pulse), .en_core(en_core), .en_vtt(en_vtt), .en_agp(en_agp), .en_mch(en_mch),
    .mch_full(mch_full), .ramp_a(ramp_a), .ramp_b(ramp_b), .ramp_a_up(ramp_a_up),
    .ramp_b_up(ramp_b_up), .vtt_pg(vtt_pg), .pgood(pgood)
  );

  // reference model: levels in counts of 20 mV
  int m_por, m_a, m_b, m_rel, m_mch, m_full, m_vtt, m_agp, m_core, m_aup, m_bup, m_vpg, m_pg;
  initial begin
    m_por = 0; m_a = 0; m_b = 0; m_rel = 0; m_mch = 0; m_full = 0; m_vtt = 0;
    m_agp = 0; m_core = 0; m_aup = 0; m_bup = 0; m_vpg = 0; m_pg = 0;
  end

  always @(posedge clk) begin
    int live, clra, clrb, na, nb, nrel;
    if (rst) begin
      m_por = 0; m_a = 0; m_b = 0; m_rel = 0; m_mch = 0; m_full = 0; m_vtt = 0;
      m_agp = 0; m_core = 0; m_aup = 0; m_bup = 0; m_vpg = 0; m_pg = 0;
    end else begin
      live = (m_por != 0 && m_a >= 40 && !inhibit) ? 1 : 0;
      clra = (m_por == 0 || shut_req || restart) ? 1 : 0;
      clrb = (clra != 0 || inhibit || m_a < 40) ? 1 : 0;
      if (clra != 0)                    na = 0;
      else if (m_a < 50)                na = 50;
      else if (tick && m_a < 225)       na = m_a + 1;
      else                              na = m_a;
      if (clrb != 0)                    nb = 0;
      else if (m_rel != 0 && tick && m_b < 225) nb = m_b + 1;
      else                              nb = m_b;
      nrel   = (clrb != 0) ? 0 : ((m_rel != 0 || vtt_90) ? 1 : 0);
      m_vtt  = live;
      m_agp  = (live != 0 && m_rel != 0) ? 1 : 0;
      m_core = (live != 0 && m_b >= 63) ? 1 : 0;
      m_mch  = 1;
      m_full = (m_por != 0 && m_a >= 40) ? 1 : 0;
      m_aup  = (m_a > 200) ? 1 : 0;
      m_bup  = (m_b > 200) ? 1 : 0;
      if (live == 0 || !vtt_uv_ok)      m_vpg = 0;
      else if (pwm_pulse && m_b >= 63)  m_vpg = 1;
      m_pg = (live != 0 && m_a > 200 && m_b > 200 && core_win && vtt_uv_ok &&
              agp_uv_ok && mch_uv_ok) ? 1 : 0;
      m_a = na; m_b = nb; m_rel = nrel;
      m_por = (sup_bias && sup_5v && sup_3v3) ? 1 : 0;
    end
  end

  task automatic check(input string req, input string nm, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check("R1", "ramp_a", int'(ramp_a), m_a);
      check("R3", "ramp_b", int'(ramp_b), m_b);
      check("R6", "ramp_a_up", int'(ramp_a_up), m_aup);
      check("R6", "ramp_b_up", int'(ramp_b_up), m_bup);
      check("R11", "en_vtt", int'(en_vtt), m_vtt);
      check("R11", "en_agp", int'(en_agp), m_agp);
      check("R11", "en_core", int'(en_core), m_core);
      check("R8", "en_mch", int'(en_mch), m_mch);
      check("R7", "mch_full", int'(mch_full), m_full);
      check("R4", "vtt_pg", int'(vtt_pg), m_vpg);
      check("R5", "pgood", int'(pgood), m_pg);
    end
  end

  always @(posedge clk) begin
    #2;
    tick_cnt++;
    tick = (tick_cnt % tick_div == 0);
  end

  task automatic go(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  initial begin
    go(5);
    rst = 0;
    go(2);
    check("R8", "en_mch after reset", int'(en_mch), 1);
    // R1: partial supplies are ignored
    sup_bias = 1; sup_5v = 1;
    go(20);
    check("R1", "ramp_a partial supplies", int'(ramp_a), 0);
    sup_3v3 = 1;
    go(3);
    check("R2", "ramp_a jump level", int'(ramp_a) >= 50 ? 1 : 0, 1);
    go(40);
    check("R3", "ramp_b before vtt_90", int'(ramp_b), 0);
    vtt_90 = 1; vtt_uv_ok = 1;
    go(20);
    pwm_pulse = 1; go(1); pwm_pulse = 0;
    check("R4", "vtt_pg below valley", int'(vtt_pg), 0);
    go(60);
    pwm_pulse = 1; go(1); pwm_pulse = 0;
    go(1);
    check("R4", "vtt_pg after valley pulse", int'(vtt_pg), 1);
    core_win = 1; agp_uv_ok = 1; mch_uv_ok = 1;
    go(250);
    check("R5", "pgood all good", int'(pgood), 1);
    check("R2", "ramp_a saturated", int'(ramp_a), 225);
    // R4: lose the termination rail, then it must wait for a pulse
    vtt_uv_ok = 0; go(3); vtt_uv_ok = 1; go(5);
    check("R4", "vtt_pg waits for pulse", int'(vtt_pg), 0);
    pwm_pulse = 1; go(1); pwm_pulse = 0; go(4);
    core_win = 0; go(4); core_win = 1; go(4);
    // R9
    inhibit = 1; go(6);
    check("R9", "ramp_b under inhibit", int'(ramp_b), 0);
    inhibit = 0; go(80);
    // R10 with slower ticks
    tick_div = 3;
    restart = 1; go(1); restart = 0;
    go(1);
    check("R10", "ramp_b after restart", int'(ramp_b), 0);
    go(400);
    pwm_pulse = 1; go(1); pwm_pulse = 0; go(200);
    // R7
    shut_req = 1; go(10);
    check("R7", "en_mch during shutdown", int'(en_mch), 1);
    check("R7", "en_vtt during shutdown", int'(en_vtt), 0);
    shut_req = 0; go(100);
    tick_div = 1;
    agp_uv_ok = 0; go(5); agp_uv_ok = 1; mch_uv_ok = 0; go(5); mch_uv_ok = 1; go(5);
    sup_5v = 0; go(6);
    check("R1", "ramp_a after supply loss", int'(ramp_a), 0);
    sup_5v = 1; go(300);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule